// File: doc/BRIEF.md
# Word-Serial Signature Compactor

This block folds a stream of data words into one signature register. It works the same way a processor computes a multiple-input signature in software. Each accepted word drives one update of the register, in three ordered steps:

1. The signature shifts one place to the right. The bit that drops out of the LSB becomes a carry, and the vacated MSB is filled with zero.
2. If that carry is one, the shifted value is XORed with the feedback polynomial.
3. The result is XORed with the incoming word.

Because of this ordering, a different word order gives a different signature.

Words arrive on a valid/ready input, and one word is absorbed per clock. Before a run, a synchronous clear loads the register with a caller-supplied seed, which is zero for a plain run. The polynomial sits in its own configuration register. It resets to a primitive 32-bit polynomial in right-shift form and can be rewritten at any time. A read strobe freezes the register for one cycle and flags the following cycle as carrying the final signature.

Top module: `sig_compactor`

## Requirements
- R1: After reset, the signature is all zeros and the read flag is low. The polynomial register holds 0xEDB88320.
- R2: An accepted word w, with current signature s and polynomial p, updates the signature at the next clock edge. The new signature is t XOR w, where t = (s >> 1, MSB filled with 0). When bit 0 of s is 1, t is additionally XORed with p.
- R3: Words are absorbed one per cycle, in arrival order. Swapping two words changes the result (words 1 then 2 from zero give p^2; 2 then 1 give 0).
- R4: in_ready_o is low exactly in cycles where read_i or clear_i is high. A word offered in such a cycle is not absorbed.
- R5: A cycle with clear_i high loads the signature with seed_i at the next edge, whatever the word input is doing.
- R6: A cycle with poly_we_i high loads poly_i into the polynomial register. Words accepted in later cycles use the new value; a word accepted in the same cycle uses the old one.
- R7: sig_valid_o is high in exactly the cycle after one where read_i is high. In that cycle sig_o equals the signature held during the read cycle.
- R8: With in_valid_i low and clear_i low, the signature does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_i | input | 1 | Load seed into signature |
| seed_i | input | WIDTH | Seed value for clear |
| in_valid_i | input | 1 | Word offered |
| in_ready_o | output | 1 | Word will be absorbed if offered |
| in_word_i | input | WIDTH | Data word |
| poly_we_i | input | 1 | Write polynomial register |
| poly_i | input | WIDTH | New polynomial |
| read_i | input | 1 | Final-read strobe |
| sig_o | output | WIDTH | Current signature |
| sig_valid_o | output | 1 | sig_o is the read result |

## Verification
The assertions assume a few things about the inputs. Every control input is a defined level at each clock edge after reset. seed_i is meaningful only in a clear cycle, and poly_i only in a write cycle. The stimulus drives every input on the falling edge, so values are settled at the rising edge. It mixes random words with clears, polynomial writes and reads that overlap offered words, which covers the contention cases of R4 through R6.

// File: rtl/sig_pkg.sv
// Shared types for the signature compactor.
// Assumes nothing beyond a SystemVerilog compiler.
package sig_pkg;
    // Next-state selection for the signature register.
    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_SEED = 2'd1,
        SEL_STEP = 2'd2
    } sig_sel_e;
endpackage

// File: rtl/sig_poly_reg.sv
// Holds the feedback polynomial used by the update step.
// Assumes poly_i is only meaningful while poly_we_i is high.
module sig_poly_reg #(
    parameter int WIDTH = 32,
    parameter logic [WIDTH-1:0] POLY_RESET = WIDTH'(32'hEDB88320)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poly_we_i,
    input  logic [WIDTH-1:0] poly_i,
    output logic [WIDTH-1:0] poly_o
);
    // Load the polynomial on a write, else keep it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poly_o <= POLY_RESET;
        end else if (poly_we_i) begin
            poly_o <= poly_i;
        end
    end

    assert_poly_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        poly_we_i |=> poly_o == $past(poly_i));
    assert_poly_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !poly_we_i |=> $stable(poly_o));
endmodule

// File: rtl/sig_step_unit.sv
// Combinational update step: right shift through carry, then a
// conditional polynomial XOR, then the XOR of the data word.
// Assumes the caller registers the result.
module sig_step_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] sig_i,
    input  logic [WIDTH-1:0] poly_i,
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] next_o
);
    logic             carry;
    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] fed_back;

    // Shift right with a zero MSB, keeping the dropped bit as carry.
    always_comb begin
        carry   = sig_i[0];
        shifted = {1'b0, sig_i[WIDTH-1:1]};
    end

    // Apply the polynomial only when the carry is set.
    always_comb begin
        fed_back = carry ? (shifted ^ poly_i) : shifted;
    end

    // Fold in the incoming word last.
    always_comb begin
        next_o = fed_back ^ word_i;
    end
endmodule

// File: rtl/sig_accum.sv
// Signature register with seed load and step update.
// Assumes sel_i is computed by the caller with clear ahead of step.
module sig_accum #(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sig_pkg::sig_sel_e sel_i,
    input  logic [WIDTH-1:0]  seed_i,
    input  logic [WIDTH-1:0]  step_i,
    output logic [WIDTH-1:0]  sig_o
);
    import sig_pkg::*;

    // Update the signature according to the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_o <= '0;
        end else begin
            case (sel_i)
                SEL_SEED: sig_o <= seed_i;
                SEL_STEP: sig_o <= step_i;
                default:  sig_o <= sig_o;
            endcase
        end
    end

    assert_seed_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == SEL_SEED |=> sig_o == $past(seed_i));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == SEL_HOLD |=> $stable(sig_o));
endmodule

// File: rtl/sig_read_strobe.sv
// Flags the cycle after a read request as carrying the final signature.
// Assumes the signature is frozen while read_i is high.
module sig_read_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic read_i,
    output logic valid_o
);
    // Delay the read request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
        end else begin
            valid_o <= read_i;
        end
    end

    assert_valid_follows_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        read_i |=> valid_o);
    assert_valid_only_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !read_i |=> !valid_o);
endmodule

// File: rtl/sig_compactor.sv
// Word-serial signature compactor top. Accepts one word per cycle
// unless a read or clear is in progress, keeps a programmable
// polynomial, and flags the read result one cycle after the strobe.
// Assumes all control inputs are defined at every clock edge.
module sig_compactor #(
    parameter int WIDTH = 32,
    parameter logic [WIDTH-1:0] POLY_RESET = WIDTH'(32'hEDB88320)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [WIDTH-1:0] in_word_i,
    input  logic             poly_we_i,
    input  logic [WIDTH-1:0] poly_i,
    input  logic             read_i,
    output logic [WIDTH-1:0] sig_o,
    output logic             sig_valid_o
);
    import sig_pkg::*;

    logic [WIDTH-1:0] poly_q;
    logic [WIDTH-1:0] step_next;
    logic             accept;
    sig_sel_e         sel;

    // Ready unless the register is being read or reloaded.
    always_comb begin
        in_ready_o = !(read_i || clear_i);
        accept     = in_valid_i && in_ready_o;
    end

    // Clear wins over a word update.
    always_comb begin
        if (clear_i)     sel = SEL_SEED;
        else if (accept) sel = SEL_STEP;
        else             sel = SEL_HOLD;
    end

    sig_poly_reg #(.WIDTH(WIDTH), .POLY_RESET(POLY_RESET)) i_poly (
        .clk(clk), .rst_n(rst_n), .poly_we_i(poly_we_i),
        .poly_i(poly_i), .poly_o(poly_q)
    );

    sig_step_unit #(.WIDTH(WIDTH)) i_step (
        .sig_i(sig_o), .poly_i(poly_q), .word_i(in_word_i), .next_o(step_next)
    );

    sig_accum #(.WIDTH(WIDTH)) i_accum (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .seed_i(seed_i),
        .step_i(step_next), .sig_o(sig_o)
    );

    sig_read_strobe i_read (
        .clk(clk), .rst_n(rst_n), .read_i(read_i), .valid_o(sig_valid_o)
    );

    assert_read_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        read_i |-> !in_ready_o);
    assert_read_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (read_i && !clear_i) |=> $stable(sig_o));
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (sig_o == '0 && !sig_valid_o));
endmodule

// File: tb/test_sig_compactor.sv
// Bench: behavioural model updated every clock and compared at negedge.
module test_sig_compactor;
    localparam int W = 32;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_i = 1'b0, in_valid_i = 1'b0, poly_we_i = 1'b0, read_i = 1'b0;
    logic [W-1:0] seed_i = '0, in_word_i = '0, poly_i = '0;
    logic in_ready_o, sig_valid_o;
    logic [W-1:0] sig_o;

    int checks = 0;
    int fails = 0;
    string req = "R1";
    logic [W-1:0] m_sig = '0;
    logic [W-1:0] m_poly = 32'hEDB88320;
    logic m_valid = 1'b0;
    logic [W-1:0] saved;

    always #4 clk = ~clk;  // 125 MHz

    sig_compactor i_sig_compactor (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .seed_i(seed_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_word_i(in_word_i),
        .poly_we_i(poly_we_i), .poly_i(poly_i), .read_i(read_i),
        .sig_o(sig_o), .sig_valid_o(sig_valid_o)
    );

    function automatic logic [W-1:0] ref_step(logic [W-1:0] s, logic [W-1:0] p, logic [W-1:0] w);
        bit c = s[0];
        s = s >> 1;
        if (c) s = s ^ p;
        return s ^ w;
    endfunction

    task automatic check(string r, logic [W-1:0] act, logic [W-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_sig = '0; m_poly = 32'hEDB88320; m_valid = 1'b0;
        end else begin
            if (clear_i) m_sig = seed_i;
            else if (in_valid_i && !read_i) m_sig = ref_step(m_sig, m_poly, in_word_i);
            if (poly_we_i) m_poly = poly_i;
            m_valid = read_i;
        end
        @(negedge clk);
        check(req, sig_o, m_sig, "signature");
        check(rst_n ? "R4" : "R1", W'(in_ready_o), W'(!(read_i || clear_i)), "ready");
        check(rst_n ? "R7" : "R1", W'(sig_valid_o), W'(m_valid), "read flag");
    endtask

    task automatic idle();
        clear_i = 0; in_valid_i = 0; poly_we_i = 0; read_i = 0;
    endtask

    task automatic push(logic [W-1:0] w);
        idle(); in_valid_i = 1; in_word_i = w; tick(); idle();
    endtask

    task automatic do_clear(logic [W-1:0] s);
        idle(); clear_i = 1; seed_i = s; tick(); idle();
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        req = "R1";
        @(negedge clk);
        tick(); tick();
        check("R1", sig_o, '0, "reset signature");
        rst_n = 1'b1;

        // R2 single steps: 5 from zero, then zero word with carry set
        req = "R2";
        push(32'h5);
        check("R2", sig_o, 32'h5, "first step");
        push(32'h0);
        check("R2", sig_o, 32'h2 ^ 32'hEDB88320, "carry step uses default poly R1");

        // R8 idle cycles hold
        req = "R8";
        saved = sig_o;
        tick(); tick();
        check("R8", sig_o, saved, "hold while idle");

        // R3 order matters
        req = "R3";
        do_clear('0); push(32'h1); push(32'h2);
        check("R3", sig_o, 32'hEDB88320 ^ 32'h2, "order 1,2");
        do_clear('0); push(32'h2); push(32'h1);
        check("R3", sig_o, 32'h0, "order 2,1");

        // R5 clear beats an offered word
        req = "R5";
        idle(); clear_i = 1; seed_i = 32'hCAFE0001; in_valid_i = 1; in_word_i = 32'hFFFF; tick(); idle();
        check("R5", sig_o, 32'hCAFE0001, "seed load with word offered");

        // R4 read blocks word; R7 flag next cycle with frozen value
        req = "R4";
        saved = sig_o;
        idle(); read_i = 1; in_valid_i = 1; in_word_i = 32'h1234; tick(); idle();
        check("R4", sig_o, saved, "word ignored during read");
        req = "R7";
        tick();
        check("R7", sig_o, saved, "read result");

        // R6 poly write: same-cycle word uses old poly, next uses new
        req = "R6";
        do_clear(32'h1);
        idle(); poly_we_i = 1; poly_i = 32'h80000057; in_valid_i = 1; in_word_i = 32'h0; tick(); idle();
        check("R6", sig_o, 32'hEDB88320, "same-cycle word uses old poly");
        do_clear(32'h1); push(32'h0);
        check("R6", sig_o, 32'h80000057, "later word uses new poly");

        // R2/R3 random streams with mixed controls
        req = "R2";
        for (int i = 0; i < 400; i++) begin
            idle();
            in_valid_i = ($urandom_range(0, 3) != 0);
            in_word_i  = $urandom();
            read_i     = ($urandom_range(0, 15) == 0);
            clear_i    = ($urandom_range(0, 31) == 0);
            seed_i     = $urandom();
            poly_we_i  = ($urandom_range(0, 31) == 0);
            poly_i     = $urandom() | 32'h80000000;
            tick();
        end
        idle();
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule